// File: doc/BRIEF.md
# Fuse Array Command Controller

This block stands between software and a one-time-programmable fuse array. Software loads a word address and, for programming, a data word into registers. It then writes a two-bit command into the control register. The controller runs the access against the array, reports what it is doing through a four-bit state code in the control register, and returns to idle when the access is done. A read leaves its result in a read-data register. A sense walks the whole array and copies every word into a bank of shadow registers, which software can then read without touching the array.

Programming is guarded in two ways. The first is a software power-good bit. The second is a lock bit: once set, it stays set until reset. A program command that finds either guard closed still runs its full time, but it leaves the array untouched and raises a sticky error flag. Programming only ever adds set bits to a word. The controller reads the old word and writes back the old word ORed with the new data.

Top module: `fuse_ctl`

## Requirements
- R1: After reset, the state code reads 4 (idle), and the error flag, read-data, power-good, lock and every shadow word read 0. Register indices are: 0 control, 1 address, 2 write data, 3 read data, 4 power-good (bit 0), 5 lock (bit 0), and DEPTH+i for shadow word i. All other indices read 0.
- R2: Control bits [1:0] are the command: 0 does nothing and the state stays at 4, 1 starts a read (state 1), 2 starts a program (state 2), and 3 starts a sense (state 3). The state code is read from control bits [19:16].
- R3: A read holds state 1 for ACC_CYCLES cycles and then returns to 4. At that point, read data holds the array word at the latched address. Read data changes at no other time.
- R4: A program holds state 2 for ACC_CYCLES cycles, then the array word becomes old | write-data. No bit is ever cleared.
- R5: A sense holds state 3 for DEPTH*ACC_CYCLES cycles, then returns to 4. Afterwards, shadow word i equals array word i.
- R6: Writing 1 to lock bit 0 sets it, and writing 0 does not clear it. A program command issued while locked leaves the array unchanged, returns to idle after ACC_CYCLES cycles, and sets the error flag (control bit 8).
- R7: A program command issued while power-good is 0 leaves the array unchanged, returns to idle after ACC_CYCLES cycles, and sets the error flag.
- R8: A command written while the state is not 4 is ignored. Address or write-data writes during an access do not alter that access.
- R9: The error flag stays set until reset, including across later successful programs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW ($clog2(DEPTH)+1) | Register index |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| fa_addr | output | AW | Array word address |
| fa_we | output | 1 | Array write strobe |
| fa_wdata | output | DW | Array write word |
| fa_rdata | input | DW | Array read word, one cycle after the address |

## Verification
Every accepted command changes the state code at the clock edge that takes the control write, so the new code is due on the first sample after that edge. Idle is due ACC_CYCLES edges later for a read or program, and DEPTH*ACC_CYCLES edges later for a sense. Read data, array words and shadow words are valid from the same sample as the return to idle. The bench drives and samples on falling edges. It counts edges from the control write and checks the busy code on the last busy cycle and the idle code on the very next one, so an access that ends one cycle early or late is caught. The test of ignored commands and address writes checks both the unchanged duration and the read result.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    typedef enum logic [3:0] {
        FST_READ  = 4'd1,
        FST_PGM   = 4'd2,
        FST_SENSE = 4'd3,
        FST_IDLE  = 4'd4
    } fst_e;

    typedef enum logic [1:0] {
        FCMD_NOP   = 2'd0,
        FCMD_READ  = 2'd1,
        FCMD_PGM   = 2'd2,
        FCMD_SENSE = 2'd3
    } fcmd_e;

    typedef struct packed {
        logic  go;
        fcmd_e cmd;
    } cmd_req_t;

    localparam int REG_CTRL  = 0;
    localparam int REG_ADDR  = 1;
    localparam int REG_WDATA = 2;
    localparam int REG_RDATA = 3;
    localparam int REG_PWR   = 4;
    localparam int REG_LOCK  = 5;

    localparam int CTRL_STATE_LSB = 16;
    localparam int CTRL_ERR_BIT   = 8;

    function automatic fst_e busy_code(fcmd_e c);
        case (c)
            FCMD_READ:  return FST_READ;
            FCMD_PGM:   return FST_PGM;
            FCMD_SENSE: return FST_SENSE;
            default:    return FST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/fuse_seq.sv
module fuse_seq
    import fuse_pkg::*;
#(
    parameter int DW         = 32,
    parameter int DEPTH      = 16,
    parameter int ACC_CYCLES = 3,
    localparam int AW        = $clog2(DEPTH),
    localparam int TW        = $clog2(ACC_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_req_t      req_i,
    input  logic [AW-1:0] op_addr_i,
    input  logic [DW-1:0] op_wdata_i,
    input  logic          pwr_i,
    input  logic          lock_i,
    output fst_e          state_o,
    output logic [AW-1:0] fa_addr_o,
    output logic          fa_we_o,
    output logic [DW-1:0] fa_wdata_o,
    input  logic [DW-1:0] fa_rdata_i,
    output logic          rd_done_o,
    output logic          sh_we_o,
    output logic [AW-1:0] sh_idx_o,
    output logic          err_set_o
);

    fst_e          st_q;
    logic [TW-1:0] tmr_q;
    logic [AW-1:0] word_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          blk_q;

    logic last;
    logic accept;
    logic pgm_blocked;

    assign last        = (tmr_q == TW'(ACC_CYCLES - 1));
    assign accept      = req_i.go && (st_q == FST_IDLE) && (req_i.cmd != FCMD_NOP);
    assign pgm_blocked = blk_q || lock_i || !pwr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= FST_IDLE;
            tmr_q   <= '0;
            word_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            blk_q   <= 1'b0;
        end else if (accept) begin
            st_q    <= busy_code(req_i.cmd);
            tmr_q   <= '0;
            word_q  <= '0;
            addr_q  <= op_addr_i;
            wdata_q <= op_wdata_i;
            blk_q   <= lock_i || !pwr_i;
        end else if (st_q != FST_IDLE) begin
            if (!last) begin
                tmr_q <= tmr_q + TW'(1);
            end else begin
                tmr_q <= '0;
                if (st_q == FST_SENSE && word_q != AW'(DEPTH - 1)) begin
                    word_q <= word_q + AW'(1);
                end else begin
                    st_q <= FST_IDLE;
                end
            end
        end
    end

    assign state_o    = st_q;
    assign fa_addr_o  = (st_q == FST_SENSE) ? word_q : addr_q;
    assign fa_we_o    = (st_q == FST_PGM) && last && !pgm_blocked;
    assign fa_wdata_o = fa_rdata_i | wdata_q;
    assign rd_done_o  = (st_q == FST_READ) && last;
    assign sh_we_o    = (st_q == FST_SENSE) && last;
    assign sh_idx_o   = word_q;
    assign err_set_o  = (st_q == FST_PGM) && last && pgm_blocked;

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q != FST_IDLE && !last) |=> (st_q == $past(st_q))); // R8
    AST_NO_PGM_LOCKED: assert property (@(posedge clk) disable iff (rst)
        lock_i |-> !fa_we_o); // R6
    AST_NO_PGM_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
        !pwr_i |-> !fa_we_o); // R7
    AST_WE_IN_PGM: assert property (@(posedge clk) disable iff (rst)
        fa_we_o |-> (st_q == FST_PGM)); // R4
    AST_SENSE_CONT: assert property (@(posedge clk) disable iff (rst)
        (sh_we_o && sh_idx_o != AW'(DEPTH - 1)) |=> (st_q == FST_SENSE)); // R5

endmodule

// File: rtl/fuse_shadow.sv
module fuse_shadow #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [AW-1:0] widx_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] ridx_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[i] <= '0;
            end else if (we_i && widx_i == AW'(i)) begin
                words[i] <= wdata_i;
            end
        end
    end

    assign rdata_o = words[ridx_i];

endmodule

// File: rtl/fuse_ctl.sv
module fuse_ctl
    import fuse_pkg::*;
#(
    parameter int DW         = 32,
    parameter int DEPTH      = 16,
    parameter int ACC_CYCLES = 3,
    localparam int AW        = $clog2(DEPTH),
    localparam int RAW       = AW + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic [AW-1:0]  fa_addr,
    output logic           fa_we,
    output logic [DW-1:0]  fa_wdata,
    input  logic [DW-1:0]  fa_rdata
);

    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          pwr_q;
    logic          lock_q;
    logic          err_q;

    cmd_req_t      req;
    fst_e          state;
    logic          rd_done;
    logic          sh_we;
    logic [AW-1:0] sh_idx;
    logic          err_set;
    logic [DW-1:0] sh_rdata;
    logic          low_we;

    assign low_we  = reg_we && !reg_addr[AW];
    assign req.go  = low_we && (reg_addr[AW-1:0] == AW'(REG_CTRL));
    assign req.cmd = fcmd_e'(reg_wdata[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            pwr_q   <= 1'b0;
            lock_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (low_we && reg_addr[AW-1:0] == AW'(REG_ADDR))  addr_q  <= reg_wdata[AW-1:0];
            if (low_we && reg_addr[AW-1:0] == AW'(REG_WDATA)) wdata_q <= reg_wdata;
            if (low_we && reg_addr[AW-1:0] == AW'(REG_PWR))   pwr_q   <= reg_wdata[0];
            if (low_we && reg_addr[AW-1:0] == AW'(REG_LOCK) && reg_wdata[0]) lock_q <= 1'b1;
            if (rd_done) rdata_q <= fa_rdata;
            if (err_set) err_q   <= 1'b1;
        end
    end

    fuse_seq #(
        .DW         (DW),
        .DEPTH      (DEPTH),
        .ACC_CYCLES (ACC_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .op_addr_i  (addr_q),
        .op_wdata_i (wdata_q),
        .pwr_i      (pwr_q),
        .lock_i     (lock_q),
        .state_o    (state),
        .fa_addr_o  (fa_addr),
        .fa_we_o    (fa_we),
        .fa_wdata_o (fa_wdata),
        .fa_rdata_i (fa_rdata),
        .rd_done_o  (rd_done),
        .sh_we_o    (sh_we),
        .sh_idx_o   (sh_idx),
        .err_set_o  (err_set)
    );

    fuse_shadow #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .we_i    (sh_we),
        .widx_i  (sh_idx),
        .wdata_i (fa_rdata),
        .ridx_i  (reg_addr[AW-1:0]),
        .rdata_o (sh_rdata)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[AW]) begin
            reg_rdata = sh_rdata;
        end else begin
            case (int'(reg_addr[AW-1:0]))
                REG_CTRL: begin
                    reg_rdata[CTRL_STATE_LSB +: 4] = state;
                    reg_rdata[CTRL_ERR_BIT]        = err_q;
                end
                REG_ADDR:  reg_rdata[AW-1:0] = addr_q;
                REG_WDATA: reg_rdata         = wdata_q;
                REG_RDATA: reg_rdata         = rdata_q;
                REG_PWR:   reg_rdata[0]      = pwr_q;
                REG_LOCK:  reg_rdata[0]      = lock_q;
                default:   reg_rdata         = '0;
            endcase
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state != FST_READ) |=> $stable(rdata_q)); // R3

endmodule

// File: tb/fuse_ctl_bench.sv
module fuse_ctl_bench;

    localparam int DW    = 32;
    localparam int DEPTH = 16;
    localparam int ACC   = 3;
    localparam int AW    = $clog2(DEPTH);
    localparam int RAW   = AW + 1;

    localparam int I_CTRL = 0, I_ADDR = 1, I_WDATA = 2, I_RDATA = 3, I_PWR = 4, I_LOCK = 5;
    localparam int NVEC = 6;
    localparam logic [35:0] VEC [NVEC] = '{
        {4'd3,  32'h0000_00F0},
        {4'd3,  32'h0F00_0000},
        {4'd0,  32'hFFFF_FFFF},
        {4'd15, 32'h8000_0001},
        {4'd7,  32'h0000_0000},
        {4'd3,  32'h0000_000F}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           reg_we = 1'b0;
    logic [RAW-1:0] reg_addr = '0;
    logic [DW-1:0]  reg_wdata = '0;
    logic [DW-1:0]  reg_rdata;
    logic [AW-1:0]  fa_addr;
    logic           fa_we;
    logic [DW-1:0]  fa_wdata;
    logic [DW-1:0]  fa_rdata = '0;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] exp_mem [DEPTH];

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (fa_we) mem[fa_addr] <= fa_wdata;
        fa_rdata <= mem[fa_addr];
    end

    fuse_ctl #(.DW(DW), .DEPTH(DEPTH), .ACC_CYCLES(ACC)) u_fuse_ctl (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fa_addr   (fa_addr),
        .fa_we     (fa_we),
        .fa_wdata  (fa_wdata),
        .fa_rdata  (fa_rdata)
    );

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    task automatic wr(input int idx, input logic [DW-1:0] d);
        @(negedge clk);
        reg_addr  = RAW'(idx);
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [DW-1:0] d);
        reg_addr = RAW'(idx);
        #1;
        d = reg_rdata;
    endtask

    task automatic state_chk(input string tag, input int want);
        logic [DW-1:0] v;
        rd(I_CTRL, v);
        check(tag, DW'(v[19:16]), DW'(want));
    endtask

    task automatic run_cmd(input string tag, input int cmd, input int code, input int dur);
        wr(I_CTRL, DW'(cmd));
        state_chk({tag, " busy start"}, code);
        repeat (dur - 1) @(negedge clk);
        state_chk({tag, " busy last"}, code);
        @(negedge clk);
        state_chk({tag, " idle"}, 4);
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]     = DW'(i) * 32'h0001_0203;
            exp_mem[i] = DW'(i) * 32'h0001_0203;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(I_CTRL, v);  check("R1 ctrl", v, 32'h0004_0000);
        rd(I_RDATA, v); check("R1 rdata", v, '0);
        rd(I_PWR, v);   check("R1 pwr", v, '0);
        rd(I_LOCK, v);  check("R1 lock", v, '0);
        rd(DEPTH + 5, v); check("R1 shadow", v, '0);
        rd(7, v);       check("R1 unused index", v, '0);

        // R2 no-op command leaves idle
        wr(I_CTRL, 32'd0);
        state_chk("R2 nop", 4);

        wr(I_PWR, 32'd1);
        rd(I_PWR, v); check("R7 pwr on", v, 32'd1);

        // R3/R4 vector walk: program then read back
        for (int k = 0; k < NVEC; k++) begin
            int a;
            a = int'(VEC[k][35:32]);
            exp_mem[a] = exp_mem[a] | VEC[k][31:0];
            wr(I_ADDR, DW'(a));
            wr(I_WDATA, VEC[k][31:0]);
            run_cmd("R4 program", 2, 2, ACC);
            run_cmd("R3 read", 1, 1, ACC);
            rd(I_RDATA, v); check("R4 or-merge readback", v, exp_mem[a]);
        end

        // R5 sense
        run_cmd("R5 sense", 3, 3, DEPTH * ACC);
        for (int i = 0; i < DEPTH; i++) begin
            rd(DEPTH + i, v); check("R5 shadow word", v, exp_mem[i]);
        end

        // R8 commands and address writes during a read are ignored
        wr(I_ADDR, 32'd3);
        wr(I_CTRL, 32'd1);
        state_chk("R8 read start", 1);
        reg_addr = RAW'(I_ADDR); reg_wdata = 32'd15; reg_we = 1'b1;
        @(negedge clk);
        reg_addr = RAW'(I_CTRL); reg_wdata = 32'd2;
        @(negedge clk);
        reg_we = 1'b0;
        state_chk("R8 still reading", 1);
        repeat (ACC - 2) @(negedge clk);
        state_chk("R8 idle on time", 4);
        rd(I_RDATA, v); check("R8 latched address", v, exp_mem[3]);
        @(negedge clk);
        state_chk("R8 no late program", 4);

        // R7 program without power
        wr(I_PWR, 32'd0);
        wr(I_ADDR, 32'd5);
        wr(I_WDATA, 32'hFFFF_0000);
        run_cmd("R7 blocked program", 2, 2, ACC);
        rd(I_CTRL, v); check("R7 error flag", DW'(v[8]), 32'd1);
        run_cmd("R7 read", 1, 1, ACC);
        rd(I_RDATA, v); check("R7 array unchanged", v, exp_mem[5]);

        // R9 error stays after a good program
        wr(I_PWR, 32'd1);
        wr(I_ADDR, 32'd9);
        wr(I_WDATA, 32'h0000_0100);
        exp_mem[9] = exp_mem[9] | 32'h0000_0100;
        run_cmd("R9 good program", 2, 2, ACC);
        rd(I_CTRL, v); check("R9 error sticky", DW'(v[8]), 32'd1);
        run_cmd("R9 read", 1, 1, ACC);
        rd(I_RDATA, v); check("R9 program landed", v, exp_mem[9]);

        // R6 lock
        wr(I_LOCK, 32'd1);
        wr(I_LOCK, 32'd0);
        rd(I_LOCK, v); check("R6 lock sticky", v, 32'd1);
        wr(I_ADDR, 32'd6);
        wr(I_WDATA, 32'hAAAA_AAAA);
        run_cmd("R6 locked program", 2, 2, ACC);
        run_cmd("R6 read", 1, 1, ACC);
        rd(I_RDATA, v); check("R6 array unchanged", v, exp_mem[6]);

        // R9/R6 reset clears error and lock
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        rd(I_CTRL, v); check("R9 error cleared by reset", v, 32'h0004_0000);
        rd(I_LOCK, v); check("R6 lock cleared by reset", v, '0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule